// File: doc/BRIEF.md
# Dual 64-bit Alarm Timer with Count Snapshot

This block holds two independent timer channels. Each channel has a 64-bit up-counter, a 64-bit alarm comparator and a 64-bit reload value. A channel counts while its run bit is set. When its armed alarm matches the count, the channel raises an interrupt request. If auto-reload is on, the counter restarts from the reload value. Software cannot read the live count directly. A command write first freezes the count into a snapshot, which is then read as a low 32-bit word and a high 32-bit word. The alarm and reload values are also written as two 32-bit halves.

A shared interrupt set serves both channels and one watchdog request from outside the block. The set has a sticky raw vector, an enable mask with separate set and clear strobes, and a write-only raw-clear strobe. Bit 0 belongs to timer 0, bit 1 to timer 1 and bit 2 to the watchdog input. The same positions are used in the raw, enable, clear and pending views. The single interrupt line is high while any raw bit is also enabled.

Top module: `alarm_timer_pair`

The register address is `{index, slot}`, with a 3-bit slot. Timer t uses index t. The shared interrupt set uses index 2, so its addresses start at 16.

Per-timer slots:
- 0: configuration. Bit 0 is run, bit 1 is auto-reload, bit 2 is alarm armed.
- 1 and 2: alarm low and high words.
- 3 and 4: reload low and high words.
- 5: command. Bit 0 takes a snapshot, bit 1 loads the reload value into the counter.
- 6 and 7: snapshot low and high words.

Shared slots:
- 0: OR into the enable mask.
- 1: clear bits of the enable mask.
- 2: clear raw bits.
- 3: read the raw vector.
- 4: read the enable mask.
- 5: read the pending vector (raw AND enable).

Writes to read-only slots have no effect.

## Requirements
- R1: With run (config bit 0) set, the counter gains one per clock, carrying across the 32-bit word boundary. With run clear, it holds its value.
- R2: Writing command bit 0 copies the present count into the snapshot. The snapshot low and high words (slots 6 and 7) keep that value until the next snapshot command, while counting continues.
- R3: While armed (config bit 2), a count equal to the full 64-bit alarm sets that timer's raw bit on the next clock. In the same step the armed bit clears itself, so it reads back as 0.
- R4: With the armed bit clear, a count passing the alarm value sets no raw bit.
- R5: With auto-reload (config bit 1) set, the count in the cycle after an alarm equals the reload value. With auto-reload clear, counting continues through the alarm.
- R6: Writing command bit 1 loads the 64-bit reload value into the counter.
- R7: A write to shared slot 0 ORs its data into the enable mask. A write to shared slot 1 clears only the enable bits that are 1 in its data.
- R8: A write to shared slot 2 clears only the raw bits that are 1 in its data. A raw bit that is set and cleared in the same cycle stays set.
- R9: Raw bits are positioned as follows: bit 0 is timer 0's alarm, bit 1 is timer 1's alarm, bit 2 is set by the watchdog input.
- R10: irq_o is high exactly when some raw bit is also enabled. Shared slot 5 reads raw AND enable.
- R11: After reset, every register reads 0 and irq_o is low.
- R12: The run, auto-reload and armed bits read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address {index, slot} |
| wr_data | input | WORD_W | Write data |
| rd_addr | input | ADDR_W | Read address {index, slot} |
| rd_data | output | WORD_W | Read data for rd_addr (combinational) |
| wdt_irq_i | input | 1 | Watchdog request; sets raw bit 2 |
| irq_o | output | 1 | OR of pending interrupt bits |
| irq_vec_o | output | N_TMR+1 | Pending vector (raw AND enable) |

## Verification
Free-running counts start from random 64-bit values and from values just below a 32-bit carry, with random idle gaps before the snapshot. This separates correct increments and carries from stale or torn snapshots. Alarm runs are tried with auto-reload on and off, and with the armed bit off. The stopped count then shows whether the reload, continued counting or a missed alarm took place. Directed cases put a raw-clear write on the very edge of an alarm and fire the alarm on the second timer and on the watchdog alone. These cases tell apart clear-versus-set priority and the bit positions.

// File: rtl/alarm_timer_pkg.sv
package alarm_timer_pkg;

    localparam int SLOT_W = 3;

    // per-timer slots
    localparam logic [SLOT_W-1:0] OFS_CFG     = 3'd0;
    localparam logic [SLOT_W-1:0] OFS_ALM_LO  = 3'd1;
    localparam logic [SLOT_W-1:0] OFS_ALM_HI  = 3'd2;
    localparam logic [SLOT_W-1:0] OFS_RLD_LO  = 3'd3;
    localparam logic [SLOT_W-1:0] OFS_RLD_HI  = 3'd4;
    localparam logic [SLOT_W-1:0] OFS_CMD     = 3'd5;
    localparam logic [SLOT_W-1:0] OFS_SNAP_LO = 3'd6;
    localparam logic [SLOT_W-1:0] OFS_SNAP_HI = 3'd7;

    // shared interrupt slots
    localparam logic [SLOT_W-1:0] SH_ENA_SET = 3'd0;
    localparam logic [SLOT_W-1:0] SH_ENA_CLR = 3'd1;
    localparam logic [SLOT_W-1:0] SH_RAW_CLR = 3'd2;
    localparam logic [SLOT_W-1:0] SH_RAW     = 3'd3;
    localparam logic [SLOT_W-1:0] SH_ENA     = 3'd4;
    localparam logic [SLOT_W-1:0] SH_PEND    = 3'd5;

    // bit positions
    localparam int CFG_RUN  = 0;
    localparam int CFG_AUTO = 1;
    localparam int CFG_ARM  = 2;
    localparam int CFG_W    = 3;
    localparam int CMD_SNAP = 0;
    localparam int CMD_LOAD = 1;

endpackage

// File: rtl/timer_channel.sv
module timer_channel
    import alarm_timer_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_sel,
    input  logic [SLOT_W-1:0]    wr_ofs,
    input  logic [WORD_W-1:0]    wr_data,
    output logic [CFG_W-1:0]     cfg_o,
    output logic [2*WORD_W-1:0]  cnt_o,
    output logic [2*WORD_W-1:0]  alarm_o,
    output logic [2*WORD_W-1:0]  reload_o,
    output logic [2*WORD_W-1:0]  snap_o,
    output logic                 hit_o
);
    localparam int CNT_W = 2 * WORD_W;

    typedef struct packed {
        logic             run;
        logic             auto_rld;
        logic             arm;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] alarm;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] snap;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     hit;

    always_comb begin
        st_d = st_q;
        hit  = st_q.arm && (st_q.cnt == st_q.alarm);

        if (st_q.run) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end

        // alarm: one-shot disarm, optional restart from reload
        if (hit) begin
            st_d.arm = 1'b0;
            if (st_q.auto_rld) begin
                st_d.cnt = st_q.reload;
            end
        end

        // register writes take priority over the automatic updates
        if (wr_sel) begin
            case (wr_ofs)
                OFS_CFG: begin
                    st_d.run      = wr_data[CFG_RUN];
                    st_d.auto_rld = wr_data[CFG_AUTO];
                    st_d.arm      = wr_data[CFG_ARM];
                end
                OFS_ALM_LO: st_d.alarm[WORD_W-1:0]      = wr_data;
                OFS_ALM_HI: st_d.alarm[CNT_W-1:WORD_W]  = wr_data;
                OFS_RLD_LO: st_d.reload[WORD_W-1:0]     = wr_data;
                OFS_RLD_HI: st_d.reload[CNT_W-1:WORD_W] = wr_data;
                OFS_CMD: begin
                    if (wr_data[CMD_SNAP]) st_d.snap = st_q.cnt;
                    if (wr_data[CMD_LOAD]) st_d.cnt  = st_q.reload;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o    = {st_q.arm, st_q.auto_rld, st_q.run};
    assign cnt_o    = st_q.cnt;
    assign alarm_o  = st_q.alarm;
    assign reload_o = st_q.reload;
    assign snap_o   = st_q.snap;
    assign hit_o    = hit;

endmodule

// File: rtl/irq_block.sv
module irq_block #(
    parameter int NB = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] set_i,
    input  logic          ena_set_we,
    input  logic          ena_clr_we,
    input  logic          raw_clr_we,
    input  logic [NB-1:0] mask_i,
    output logic [NB-1:0] raw_o,
    output logic [NB-1:0] ena_o,
    output logic [NB-1:0] pend_o,
    output logic          irq_o
);
    typedef struct packed {
        logic [NB-1:0] raw;
        logic [NB-1:0] ena;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // set beats clear when both land in one cycle
        if (raw_clr_we) st_d.raw = st_q.raw & ~mask_i;
        st_d.raw = st_d.raw | set_i;
        if (ena_set_we) st_d.ena = st_q.ena | mask_i;
        if (ena_clr_we) st_d.ena = st_q.ena & ~mask_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_o  = st_q.raw;
    assign ena_o  = st_q.ena;
    assign pend_o = st_q.raw & st_q.ena;
    assign irq_o  = |pend_o;

endmodule

// File: rtl/alarm_timer_pair.sv
module alarm_timer_pair
    import alarm_timer_pkg::*;
#(
    parameter int N_TMR  = 2,
    parameter int WORD_W = 32,
    parameter int ADDR_W = $clog2(N_TMR * 8 + 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              wdt_irq_i,
    output logic              irq_o,
    output logic [N_TMR:0]    irq_vec_o
);
    localparam int CNT_W = 2 * WORD_W;
    localparam int NB    = N_TMR + 1;
    localparam int IDX_W = ADDR_W - SLOT_W;

    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic [SLOT_W-1:0] wr_ofs, rd_ofs;

    assign wr_idx = wr_addr[ADDR_W-1:SLOT_W];
    assign wr_ofs = wr_addr[SLOT_W-1:0];
    assign rd_idx = rd_addr[ADDR_W-1:SLOT_W];
    assign rd_ofs = rd_addr[SLOT_W-1:0];

    logic [N_TMR-1:0][CFG_W-1:0] cfg_w;
    logic [N_TMR-1:0][CNT_W-1:0] cnt_w, alm_w, rld_w, snap_w;
    logic [N_TMR-1:0]            hit_w, arm_w, auto_w;
    logic [NB-1:0]               raw_w, ena_w, pend_w;

    for (genvar t = 0; t < N_TMR; t++) begin : g_chan
        logic sel;
        assign sel      = wr_en && (wr_idx == IDX_W'(t));
        assign arm_w[t]  = cfg_w[t][CFG_ARM];
        assign auto_w[t] = cfg_w[t][CFG_AUTO];

        timer_channel #(.WORD_W(WORD_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sel   (sel),
            .wr_ofs   (wr_ofs),
            .wr_data  (wr_data),
            .cfg_o    (cfg_w[t]),
            .cnt_o    (cnt_w[t]),
            .alarm_o  (alm_w[t]),
            .reload_o (rld_w[t]),
            .snap_o   (snap_w[t]),
            .hit_o    (hit_w[t])
        );
    end

    logic sh_sel;
    assign sh_sel = wr_en && (wr_idx == IDX_W'(N_TMR));

    irq_block #(.NB(NB)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      ({wdt_irq_i, hit_w}),
        .ena_set_we (sh_sel && (wr_ofs == SH_ENA_SET)),
        .ena_clr_we (sh_sel && (wr_ofs == SH_ENA_CLR)),
        .raw_clr_we (sh_sel && (wr_ofs == SH_RAW_CLR)),
        .mask_i     (wr_data[NB-1:0]),
        .raw_o      (raw_w),
        .ena_o      (ena_w),
        .pend_o     (pend_w),
        .irq_o      (irq_o)
    );

    assign irq_vec_o = pend_w;

    always_comb begin
        rd_data = '0;
        for (int t = 0; t < N_TMR; t++) begin
            if (rd_idx == IDX_W'(t)) begin
                case (rd_ofs)
                    OFS_CFG:     rd_data = WORD_W'(cfg_w[t]);
                    OFS_ALM_LO:  rd_data = alm_w[t][WORD_W-1:0];
                    OFS_ALM_HI:  rd_data = alm_w[t][CNT_W-1:WORD_W];
                    OFS_RLD_LO:  rd_data = rld_w[t][WORD_W-1:0];
                    OFS_RLD_HI:  rd_data = rld_w[t][CNT_W-1:WORD_W];
                    OFS_SNAP_LO: rd_data = snap_w[t][WORD_W-1:0];
                    OFS_SNAP_HI: rd_data = snap_w[t][CNT_W-1:WORD_W];
                    default:     rd_data = '0;
                endcase
            end
        end
        if (rd_idx == IDX_W'(N_TMR)) begin
            case (rd_ofs)
                SH_RAW:  rd_data = WORD_W'(raw_w);
                SH_ENA:  rd_data = WORD_W'(ena_w);
                SH_PEND: rd_data = WORD_W'(pend_w);
                default: rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/alarm_timer_pair_chk.sv
module alarm_timer_pair_chk
    import alarm_timer_pkg::*;
#(
    parameter int N_TMR  = 2,
    parameter int WORD_W = 32,
    parameter int ADDR_W = 5
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              wr_en,
    input logic [ADDR_W-1:0]                 wr_addr,
    input logic [WORD_W-1:0]                 wr_data,
    input logic                              wdt_irq_i,
    input logic                              irq_o,
    input logic [N_TMR-1:0]                  hit,
    input logic [N_TMR-1:0]                  arm,
    input logic [N_TMR-1:0]                  auto_rld,
    input logic [N_TMR-1:0][2*WORD_W-1:0]    cnt,
    input logic [N_TMR-1:0][2*WORD_W-1:0]    rld,
    input logic [N_TMR:0]                    raw,
    input logic [N_TMR:0]                    ena
);
    localparam int NB = N_TMR + 1;

    logic raw_clr_wr, ena_clr_wr;
    assign raw_clr_wr = wr_en && (wr_addr == ADDR_W'(N_TMR * 8 + int'(SH_RAW_CLR)));
    assign ena_clr_wr = wr_en && (wr_addr == ADDR_W'(N_TMR * 8 + int'(SH_ENA_CLR)));

    for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
        logic cfg_wr, cmd_wr;
        assign cfg_wr = wr_en && (wr_addr == ADDR_W'(t * 8 + int'(OFS_CFG)));
        assign cmd_wr = wr_en && (wr_addr == ADDR_W'(t * 8 + int'(OFS_CMD)));

        a_r3_hit_sets_raw: assert property (@(posedge clk) disable iff (!rst_n)
            hit[t] |=> raw[t]);

        a_r3_hit_disarms: assert property (@(posedge clk) disable iff (!rst_n)
            hit[t] && !cfg_wr |=> !arm[t]);

        a_r5_reload_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
            hit[t] && auto_rld[t] && !cmd_wr |=> cnt[t] == $past(rld[t]));
    end

    for (genvar b = 0; b < NB; b++) begin : g_bit
        a_r8_raw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            raw[b] && !(raw_clr_wr && wr_data[b]) |=> raw[b]);

        a_r7_ena_clear: assert property (@(posedge clk) disable iff (!rst_n)
            ena_clr_wr && wr_data[b] |=> !ena[b]);
    end

    a_r9_wdt_raw: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_irq_i |=> raw[N_TMR]);

    a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ena == '0) |-> !irq_o);

endmodule

bind alarm_timer_pair alarm_timer_pair_chk #(
    .N_TMR  (N_TMR),
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wdt_irq_i (wdt_irq_i),
    .irq_o     (irq_o),
    .hit       (hit_w),
    .arm       (arm_w),
    .auto_rld  (auto_w),
    .cnt       (cnt_w),
    .rld       (rld_w),
    .raw       (raw_w),
    .ena       (ena_w)
);

// File: tb/alarm_timer_pair_tb.sv
`timescale 1ns/1ps
module alarm_timer_pair_tb;
    localparam int N_TMR  = 2;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 5;
    localparam int SH     = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [WORD_W-1:0] wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [WORD_W-1:0] rd_data;
    logic              wdt_irq_i = 1'b0;
    logic              irq_o;
    logic [N_TMR:0]    irq_vec_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    alarm_timer_pair #(.N_TMR(N_TMR), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .wdt_irq_i(wdt_irq_i), .irq_o(irq_o), .irq_vec_o(irq_vec_o)
    );

    // expected-value models
    function automatic logic [63:0] exp_free(logic [63:0] v, int k);
        return v + 64'(1 + k);          // run write, k idle, snapshot
    endfunction
    function automatic logic [63:0] exp_stop_plain(logic [63:0] v, int k);
        return v + 64'(2 + k);          // run write, k idle, stop write
    endfunction
    function automatic logic [63:0] exp_stop_auto(logic [63:0] r, int k);
        return r + 64'(k - 4);          // alarm at v+5 reloads r, then stop
    endfunction

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        rd_addr = ADDR_W'(a);
        #1;
        d = rd_data;
    endtask

    task automatic load(int t, logic [63:0] v);
        wr(t*8 + 3, v[31:0]);
        wr(t*8 + 4, v[63:32]);
        wr(t*8 + 5, 32'h2);
    endtask

    task automatic set_alarm(int t, logic [63:0] v);
        wr(t*8 + 1, v[31:0]);
        wr(t*8 + 2, v[63:32]);
    endtask

    task automatic snap(int t, output logic [63:0] v);
        logic [31:0] lo, hi;
        wr(t*8 + 5, 32'h1);
        rd(t*8 + 6, lo);
        rd(t*8 + 7, hi);
        v = {hi, lo};
    endtask

    task automatic read_snap(int t, output logic [63:0] v);
        logic [31:0] lo, hi;
        rd(t*8 + 6, lo);
        rd(t*8 + 7, hi);
        v = {hi, lo};
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [63:0] v, r, got, got2;
        int k, seed, t;
        seed = int'($urandom(32'd4242));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        for (int a = 0; a < SH + 6; a++) begin
            rd(a, d);
            chk("R11 reset register", 64'(d), 64'h0);
        end
        chk("R11 irq after reset", 64'(irq_o), 64'h0);

        // R12: configuration readback
        wr(0, 32'h6); rd(0, d); chk("R12 cfg readback", 64'(d), 64'h6);
        wr(8, 32'h3); rd(8, d); chk("R12 cfg readback t1", 64'(d), 64'h3);
        wr(0, 32'h0); wr(8, 32'h0);

        // R6: load then snapshot while stopped
        for (int i = 0; i < 6; i++) begin
            t = i % 2;
            v = {$urandom(), $urandom()};
            load(t, v);
            snap(t, got);
            chk("R6 load value", got, v);
        end

        // R1/R2: free run, carry, random gaps
        for (int i = 0; i < 16; i++) begin
            t = int'($urandom() % 2);
            k = int'($urandom() % 8);
            v = (i < 4) ? 64'h0000_0000_FFFF_FFFE - 64'(i) : {$urandom(), $urandom()};
            load(t, v);
            wr(t*8, 32'h1);
            repeat (k) @(negedge clk);
            snap(t, got);
            chk("R1 count after run", got, exp_free(v, k));
            repeat (5) @(negedge clk);
            read_snap(t, got2);
            chk("R2 snapshot frozen", got2, got);
            wr(t*8, 32'h0);
            snap(t, got);
            repeat (4) @(negedge clk);
            snap(t, got2);
            chk("R1 hold when stopped", got2, got);
        end

        // R3/R5: alarm with and without auto-reload
        for (int i = 0; i < 8; i++) begin
            t = i % 2;
            k = 6 + int'($urandom() % 10);
            v = {$urandom(), $urandom()};
            r = {$urandom(), $urandom()};
            wr(SH + 2, 32'h7);
            load(t, r); load(t, v);              // reload ends as v
            wr(t*8 + 3, r[31:0]); wr(t*8 + 4, r[63:32]);
            set_alarm(t, v + 64'd5);
            wr(t*8, (i < 4) ? 32'h7 : 32'h5);
            repeat (k) @(negedge clk);
            rd(t*8, d);
            chk("R3 arm self-clears", 64'(d), (i < 4) ? 64'h3 : 64'h1);
            rd(SH + 3, d);
            chk("R3 raw bit set", 64'(d), 64'(1 << t));
            wr(t*8, 32'h0);
            snap(t, got);
            chk("R5 count after alarm", got,
                (i < 4) ? exp_stop_auto(r, k) : exp_stop_plain(v, k));
        end

        // R4: alarm not armed
        wr(SH + 2, 32'h7);
        v = 64'h0000_0001_FFFF_FFF0;
        load(0, v);
        set_alarm(0, v + 64'd5);
        wr(0, 32'h1);
        repeat (10) @(negedge clk);
        rd(SH + 3, d);
        chk("R4 no raw when disarmed", 64'(d), 64'h0);
        wr(0, 32'h0);
        snap(0, got);
        chk("R4 count passes alarm", got, exp_stop_plain(v, 10));

        // R7: enable mask set / clear
        wr(SH + 0, 32'h1); wr(SH + 0, 32'h4);
        rd(SH + 4, d); chk("R7 enable OR", 64'(d), 64'h5);
        wr(SH + 1, 32'h1);
        rd(SH + 4, d); chk("R7 enable clear selected", 64'(d), 64'h4);
        wr(SH + 1, 32'h4);

        // R8: set and clear on the same edge
        v = 64'h10;
        load(0, v);
        set_alarm(0, v + 64'd5);
        wr(0, 32'h5);
        repeat (4) @(negedge clk);
        wr(SH + 2, 32'h1);
        rd(SH + 3, d);
        chk("R8 set wins same cycle", 64'(d), 64'h1);
        wr(0, 32'h0);

        // R10: masked line
        chk("R10 irq low when disabled", 64'(irq_o), 64'h0);
        wr(SH + 0, 32'h1);
        chk("R10 irq high when enabled", 64'(irq_o), 64'h1);
        rd(SH + 5, d); chk("R10 pending view", 64'(d), 64'h1);
        chk("R10 irq vector", 64'(irq_vec_o), 64'h1);

        // R8: plain clear
        wr(SH + 2, 32'h1);
        rd(SH + 3, d); chk("R8 raw cleared", 64'(d), 64'h0);
        chk("R10 irq low after clear", 64'(irq_o), 64'h0);

        // R9: bit positions
        v = 64'h0000_0000_FFFF_FFFC;
        load(1, v);
        set_alarm(1, v + 64'd5);
        wr(8, 32'h5);
        repeat (10) @(negedge clk);
        rd(SH + 3, d); chk("R9 timer1 bit", 64'(d), 64'h2);
        wr(8, 32'h0);
        wr(SH + 2, 32'h7);
        @(negedge clk); wdt_irq_i = 1'b1;
        @(negedge clk); wdt_irq_i = 1'b0;
        rd(SH + 3, d); chk("R9 watchdog bit", 64'(d), 64'h4);
        wr(SH + 2, 32'h3);
        rd(SH + 3, d); chk("R8 clear other bits only", 64'(d), 64'h4);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule